// File: doc/BRIEF.md
# Cross-Domain Peripheral Control Register

This block is the bus-side control register of a peripheral whose core logic runs on its own clock. Software sees an 8-bit control register with three live bits: a software-reset bit, an enable bit and a run-in-standby bit. It also sees a status register with a busy flag, a debug-control register and a small parameterized set of sibling configuration registers. The enable and software-reset commands cross into the core clock domain through a toggle request/acknowledge handshake. Each side uses a two-flop synchronizer. The busy flag is high from the write that starts a transfer until the returned acknowledge has been synchronized back to the bus clock.

The enable bit reads back the written value in the cycle after the write. The core-side enable follows later, once the handshake lands. A software reset clears the control bits and every sibling register at once, leaves the debug-control register untouched, and sends a one-cycle reset pulse and a disable into the core domain. A write-protect input blocks writes to the control and sibling registers. The run-in-standby bit reaches the core through a plain synchronizer and decides whether the core stays active while the core-side standby input is high.

All ports are plain control and status pins. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `pctl_sync_ctrl`

## Requirements
- R1: After reset the control register (address 0), status register (address 1), debug register (address 2) and sibling registers (addresses 3 and up) all read 0x00, and `core_enable` and `core_active` are 0.
- R2: Control bits 7:3 always read 0 whatever value was written. The control layout is bit 0 software reset, bit 1 enable, bit 2 run-in-standby.
- R3: An accepted control write with bit 0 clear shows the written enable and run-in-standby values on read-back in the next bus cycle. From that same cycle, status bit 0 (busy) reads 1.
- R4: Busy clears only after `core_enable` equals the enable value written. It clears within 16 bus cycles at the default clock ratio.
- R5: A control write that arrives while busy is 1 is ignored entirely.
- R6: A control write with bit 0 set discards the other written bits. On the next cycle the control register reads 0x01 and busy reads 1. Every sibling register reads 0x00 and the debug register keeps its value. The core domain drops `core_enable` and pulses `core_swrst_pulse` high for exactly one core cycle.
- R7: While a software reset is in progress, control bit 0 reads 1 in every cycle in which busy reads 1. Both bits read 0 from the same cycle on.
- R8: A control write with bit 0 clear leaves the sibling and debug registers unchanged.
- R9: While `wp_on` is 1, writes to the control and sibling registers are ignored, including software-reset writes. Debug-register writes are still accepted.
- R10: `core_active` is 1 exactly when `core_enable` is 1 and either `core_standby` is 0 or the synchronized run-in-standby bit is 1.
- R11: The status register ignores writes. Its bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 8 | Write data |
| wp_on | input | 1 | Write protection for control and sibling registers |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | 8 | Combinational read data |
| sib_cfg | output | NUM_SIB*8 | Sibling register contents, register 0 in the low byte |
| dbg_ctrl | output | 8 | Debug-control register contents |
| core_clk | input | 1 | Peripheral core clock |
| core_rst_n | input | 1 | Core-side asynchronous reset, active low |
| core_standby | input | 1 | Standby sleep indication in the core domain |
| core_enable | output | 1 | Enable as applied in the core domain |
| core_active | output | 1 | Core may run this cycle |
| core_swrst_pulse | output | 1 | One-core-cycle software-reset pulse |

## Verification
Suppose the request toggle and the synchronized acknowledge disagree, or the handshake payload is captured wrongly. Busy then sticks at 1, or `core_enable` differs from the read-back value when busy drops. A poll of the status register shows either fault within about a dozen bus cycles. A wrong reset decode shows on the very next read: control reads something other than 0x01, or a sibling register still holds data. A lost or doubled core reset pulse shows in the count of `core_swrst_pulse` cycles once the handshake completes.

// File: rtl/pctl_pkg.sv
`timescale 1ns/1ps
package pctl_pkg;
  localparam int DATA_W = 8;

  // control register bit positions (software decodes these)
  localparam int BIT_SWRST   = 0;
  localparam int BIT_ENABLE  = 1;
  localparam int BIT_RUNSTBY = 2;

  // status register bit position
  localparam int BIT_BUSY = 0;

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_DBG  = 2;
  localparam int ADDR_SIB0 = 3;

  // handshake payload carried alongside the request toggle
  typedef struct packed {
    logic is_rst;
    logic en;
  } xreq_t;
endpackage

// File: rtl/pctl_sync_ff.sv
`timescale 1ns/1ps
module pctl_sync_ff #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pctl_bus_regs.sv
`timescale 1ns/1ps
module pctl_bus_regs import pctl_pkg::*; #(
  parameter int ADDR_W  = 3,
  parameter int NUM_SIB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wp_on,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     ack_sync,
  output logic                     req_tgl,
  output xreq_t                    req_pay,
  output logic                     run_stdby,
  output logic [NUM_SIB*DATA_W-1:0] sib_cfg,
  output logic [DATA_W-1:0]        dbg_ctrl,
  output logic                     busy,
  output logic                     ctrl_en,
  output logic                     ctrl_sw
);
  localparam int SIB_LAST = ADDR_SIB0 + NUM_SIB - 1;

  logic              en_q, rs_q, op_rst_q, tgl_q;
  logic [DATA_W-1:0] dbg_q;
  logic [NUM_SIB-1:0][DATA_W-1:0] sib_q;

  logic ctrl_hit, ctrl_ok, rst_start, rst_run, dbg_hit;

  // busy is the open distance between the sent toggle and the returned one
  assign busy      = tgl_q ^ ack_sync;
  assign rst_run   = busy & op_rst_q;
  assign ctrl_hit  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign ctrl_ok   = ctrl_hit && !wp_on && !busy;
  assign rst_start = ctrl_ok && wr_data[BIT_SWRST];
  assign dbg_hit   = wr_en && (wr_addr == ADDR_W'(ADDR_DBG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rs_q     <= 1'b0;
      op_rst_q <= 1'b0;
      tgl_q    <= 1'b0;
    end else if (ctrl_ok) begin
      tgl_q <= ~tgl_q;
      if (wr_data[BIT_SWRST]) begin
        // reset wins: the other written bits are dropped
        en_q     <= 1'b0;
        rs_q     <= 1'b0;
        op_rst_q <= 1'b1;
      end else begin
        en_q     <= wr_data[BIT_ENABLE];
        rs_q     <= wr_data[BIT_RUNSTBY];
        op_rst_q <= 1'b0;
      end
    end
  end

  // debug register survives software reset and ignores protection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbg_q <= '0;
    else if (dbg_hit) dbg_q <= wr_data;
  end

  // sibling registers: cleared by software reset, protected writes
  for (genvar g = 0; g < NUM_SIB; g++) begin : g_sib
    logic hit;
    assign hit = wr_en && !wp_on && !rst_run &&
                 (wr_addr == ADDR_W'(ADDR_SIB0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sib_q[g] <= '0;
      else if (rst_start) sib_q[g] <= '0;
      else if (hit)       sib_q[g] <= wr_data;
    end
    assign sib_cfg[g*DATA_W +: DATA_W] = sib_q[g];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_data[BIT_SWRST]   = rst_run;
      rd_data[BIT_ENABLE]  = en_q;
      rd_data[BIT_RUNSTBY] = rs_q;
    end else if (rd_addr == ADDR_W'(ADDR_STAT)) begin
      rd_data[BIT_BUSY] = busy;
    end else if (rd_addr == ADDR_W'(ADDR_DBG)) begin
      rd_data = dbg_q;
    end else begin
      for (int i = ADDR_SIB0; i <= SIB_LAST; i++) begin
        if (rd_addr == ADDR_W'(i)) rd_data = sib_q[i-ADDR_SIB0];
      end
    end
  end

  assign req_tgl        = tgl_q;
  assign req_pay.is_rst = op_rst_q;
  assign req_pay.en     = en_q;
  assign run_stdby      = rs_q;
  assign dbg_ctrl       = dbg_q;
  assign ctrl_en        = en_q;
  assign ctrl_sw        = rst_run;
endmodule

// File: rtl/pctl_core_side.sv
`timescale 1ns/1ps
module pctl_core_side import pctl_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_tgl,
  input  xreq_t req_pay,
  input  logic  run_stdby,
  input  logic  standby,
  output logic  ack_tgl,
  output logic  enable,
  output logic  active,
  output logic  swrst_pulse
);
  logic [1:0] sync_q;
  logic       req_s, rs_s, seen_q, en_q, pulse_q;

  pctl_sync_ff #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({run_stdby, req_tgl}),
    .q    (sync_q)
  );
  assign req_s = sync_q[0];
  assign rs_s  = sync_q[1];

  // payload is held steady on the bus side while busy, so it is sampled
  // only once the synchronized toggle shows a new request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (req_s != seen_q) begin
        seen_q <= req_s;
        if (req_pay.is_rst) begin
          en_q    <= 1'b0;
          pulse_q <= 1'b1;
        end else begin
          en_q <= req_pay.en;
        end
      end
    end
  end

  assign ack_tgl     = seen_q;
  assign enable      = en_q;
  assign active      = en_q & (~standby | rs_s);
  assign swrst_pulse = pulse_q;
endmodule

// File: rtl/pctl_sync_ctrl.sv
`timescale 1ns/1ps
module pctl_sync_ctrl import pctl_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int NUM_SIB     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      bus_clk,
  input  logic                      bus_rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      wp_on,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic [NUM_SIB*8-1:0]      sib_cfg,
  output logic [7:0]                dbg_ctrl,
  input  logic                      core_clk,
  input  logic                      core_rst_n,
  input  logic                      core_standby,
  output logic                      core_enable,
  output logic                      core_active,
  output logic                      core_swrst_pulse
);
  logic  req_tgl_w, ack_tgl_w, ack_sync_w, run_stdby_w;
  logic  busy_w, ctrl_en_w, ctrl_sw_w;
  xreq_t req_pay_w;

  pctl_bus_regs #(.ADDR_W(ADDR_W), .NUM_SIB(NUM_SIB)) u_bus (
    .clk      (bus_clk),
    .rst_n    (bus_rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wp_on    (wp_on),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ack_sync (ack_sync_w),
    .req_tgl  (req_tgl_w),
    .req_pay  (req_pay_w),
    .run_stdby(run_stdby_w),
    .sib_cfg  (sib_cfg),
    .dbg_ctrl (dbg_ctrl),
    .busy     (busy_w),
    .ctrl_en  (ctrl_en_w),
    .ctrl_sw  (ctrl_sw_w)
  );

  pctl_sync_ff #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (bus_clk),
    .rst_n(bus_rst_n),
    .d    (ack_tgl_w),
    .q    (ack_sync_w)
  );

  pctl_core_side #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk        (core_clk),
    .rst_n      (core_rst_n),
    .req_tgl    (req_tgl_w),
    .req_pay    (req_pay_w),
    .run_stdby  (run_stdby_w),
    .standby    (core_standby),
    .ack_tgl    (ack_tgl_w),
    .enable     (core_enable),
    .active     (core_active),
    .swrst_pulse(core_swrst_pulse)
  );
endmodule

// File: rtl/pctl_sync_ctrl_chk.sv
`timescale 1ns/1ps
module pctl_sync_ctrl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_low,
  input logic              wp_on,
  input logic              busy,
  input logic              ctrl_en,
  input logic              ctrl_sw,
  input logic              core_clk,
  input logic              core_rst_n,
  input logic              core_standby,
  input logic              core_enable,
  input logic              core_active,
  input logic              core_swrst_pulse
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);

  // R3
  en_readback_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_wr && !wp_on && !busy && !wr_low[0]) |=> (busy && ctrl_en == $past(wr_low[1])));

  // R5
  busy_ignore_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_wr && busy) |=> $stable(ctrl_en));

  // R9
  wp_ignore_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_wr && wp_on && !busy) |=> ($stable(ctrl_en) && !busy));

  // R6
  rst_precedence_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_wr && !wp_on && !busy && wr_low[0]) |=> (ctrl_sw && !ctrl_en));

  // R7
  rst_under_busy_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ctrl_sw |-> busy);

  // R6
  core_pulse_single_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_swrst_pulse |=> !core_swrst_pulse);

  // R6
  core_pulse_disable_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_swrst_pulse |-> !core_enable);

  // R10
  awake_active_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (core_enable && !core_standby) |-> core_active);

  // R10
  off_idle_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !core_enable |-> !core_active);
endmodule

bind pctl_sync_ctrl pctl_sync_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .bus_clk         (bus_clk),
  .bus_rst_n       (bus_rst_n),
  .wr_en           (wr_en),
  .wr_addr         (wr_addr),
  .wr_low          (wr_data[1:0]),
  .wp_on           (wp_on),
  .busy            (busy_w),
  .ctrl_en         (ctrl_en_w),
  .ctrl_sw         (ctrl_sw_w),
  .core_clk        (core_clk),
  .core_rst_n      (core_rst_n),
  .core_standby    (core_standby),
  .core_enable     (core_enable),
  .core_active     (core_active),
  .core_swrst_pulse(core_swrst_pulse)
);

// File: tb/pctl_sync_ctrl_test.sv
`timescale 1ns/1ps
module pctl_sync_ctrl_test;
  logic       bus_clk = 1'b0, core_clk = 1'b0;
  logic       bus_rst_n = 1'b0, core_rst_n = 1'b0;
  logic       wr_en = 1'b0, wp_on = 1'b0, core_standby = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, dbg_ctrl;
  logic [15:0] sib_cfg;
  logic       core_enable, core_active, core_swrst_pulse;

  int checks = 0, fails = 0, pulse_cnt = 0;
  bit done = 1'b0;

  always #2 bus_clk = ~bus_clk;      // 250 MHz
  always #3.5 core_clk = ~core_clk;  // unrelated core clock

  pctl_sync_ctrl uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_on(wp_on), .rd_addr(rd_addr), .rd_data(rd_data),
    .sib_cfg(sib_cfg), .dbg_ctrl(dbg_ctrl), .core_clk(core_clk),
    .core_rst_n(core_rst_n), .core_standby(core_standby),
    .core_enable(core_enable), .core_active(core_active),
    .core_swrst_pulse(core_swrst_pulse)
  );

  always @(posedge core_clk) if (core_swrst_pulse) pulse_cnt++;

  // {req[23:20], wp[19], addr[18:16], wdata[15:8], expected read-back[7:0]}
  localparam logic [23:0] VEC [8] = '{
    {4'd3,  1'b0, 3'd0, 8'h02, 8'h02},  // R3 enable on
    {4'd2,  1'b0, 3'd0, 8'hFE, 8'h06},  // R2 reserved bits read 0
    {4'd9,  1'b1, 3'd0, 8'h04, 8'h06},  // R9 protected control write
    {4'd9,  1'b0, 3'd3, 8'h5A, 8'h5A},  // R9 open sibling write
    {4'd9,  1'b1, 3'd4, 8'hC3, 8'h00},  // R9 protected sibling write
    {4'd9,  1'b1, 3'd2, 8'h81, 8'h81},  // R9 debug ignores protection
    {4'd11, 1'b0, 3'd1, 8'hFF, 8'h00},  // R11 status ignores writes
    {4'd8,  1'b0, 3'd0, 8'h02, 8'h02}   // R8 plain control write
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic p);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wp_on = p;
    @(negedge bus_clk);
    wr_en = 1'b0; wp_on = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      bus_read(3'd1, s);
      if (s[0] == 1'b0) break;
      n++;
      @(negedge bus_clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, s;
    int n, p0;
    logic prev_busy;

    repeat (5) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    core_rst_n = 1'b1;
    repeat (3) @(negedge bus_clk);

    // R1 reset state
    bus_read(3'd0, r); chk(r, 8'h00, 1, "control after reset");
    bus_read(3'd1, r); chk(r, 8'h00, 1, "status after reset");
    bus_read(3'd2, r); chk(r, 8'h00, 1, "debug after reset");
    bus_read(3'd3, r); chk(r, 8'h00, 1, "sibling after reset");
    chk({6'd0, core_enable, core_active}, 8'h00, 1, "core outputs after reset");

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = VEC[i];
      bus_write(v[18:16], v[15:8], v[19]);
      bus_read(v[18:16], r);
      chk(r, v[7:0], int'(v[23:20]), $sformatf("table %0d read-back", i));
      bus_read(3'd1, s);
      if (v[18:16] == 3'd0 && !v[19]) begin
        chk(s, 8'h01, 3, $sformatf("table %0d busy set", i));          // R3
        wait_idle(n);
        chk(8'((n >= 2 && n <= 16) ? 1 : 0), 8'h01, 4,
            $sformatf("table %0d busy length %0d", i, n));              // R4
        chk({7'd0, core_enable}, {7'd0, v[1]}, 4,
            $sformatf("table %0d core enable at idle", i));             // R4
      end else begin
        chk(s, 8'h00, 9, $sformatf("table %0d no transfer", i));        // R9, R11
      end
    end

    // R8 sibling and debug untouched by plain control write
    bus_read(3'd3, r); chk(r, 8'h5A, 8, "sibling kept");
    chk(dbg_ctrl, 8'h81, 8, "debug kept");

    // R10 standby behaviour
    @(negedge core_clk) core_standby = 1'b1;
    repeat (4) @(negedge core_clk);
    chk({7'd0, core_active}, 8'h00, 10, "standby halts without run-in-standby");
    bus_write(3'd0, 8'h06, 1'b0); wait_idle(n);
    repeat (4) @(negedge core_clk);
    chk({7'd0, core_active}, 8'h01, 10, "standby runs with run-in-standby");
    @(negedge core_clk) core_standby = 1'b0;
    bus_write(3'd0, 8'h02, 1'b0); wait_idle(n);
    repeat (4) @(negedge core_clk);
    chk({7'd0, core_active}, 8'h01, 10, "awake runs");

    // R5 second write during busy dropped
    bus_write(3'd0, 8'h00, 1'b0);
    bus_read(3'd1, s); chk(s, 8'h01, 3, "busy after disable write");
    bus_write(3'd0, 8'h02, 1'b0);
    wait_idle(n);
    bus_read(3'd0, r); chk(r, 8'h00, 5, "write during busy ignored");
    chk({7'd0, core_enable}, 8'h00, 5, "core stays disabled");

    // R6 software reset precedence and fan-out
    bus_write(3'd4, 8'h11, 1'b0);
    bus_write(3'd0, 8'h02, 1'b0); wait_idle(n);
    p0 = pulse_cnt;
    bus_write(3'd0, 8'h07, 1'b0);
    bus_read(3'd0, r); chk(r, 8'h01, 6, "reset discards enable and standby bits");
    bus_read(3'd1, s); chk(s, 8'h01, 6, "busy during reset");
    chk(sib_cfg[7:0], 8'h00, 6, "sibling 0 cleared");
    chk(sib_cfg[15:8], 8'h00, 6, "sibling 1 cleared");
    chk(dbg_ctrl, 8'h81, 6, "debug preserved");

    // R7 reset bit and busy fall together
    prev_busy = 1'b1;
    for (int k = 0; k < 400 && prev_busy; k++) begin
      @(negedge bus_clk);
      bus_read(3'd1, s);
      bus_read(3'd0, r);
      chk({7'd0, r[0]}, {7'd0, s[0]}, 7, $sformatf("reset bit vs busy cycle %0d", k));
      prev_busy = s[0];
    end
    chk({7'd0, prev_busy}, 8'h00, 7, "reset completes");
    repeat (3) @(negedge core_clk);
    chk(8'(pulse_cnt - p0), 8'h01, 6, "one core reset pulse");
    chk({7'd0, core_enable}, 8'h00, 6, "core disabled after reset");

    // R9 protected reset write ignored
    bus_write(3'd3, 8'h22, 1'b0);
    bus_write(3'd0, 8'h01, 1'b1);
    bus_read(3'd1, s); chk(s, 8'h00, 9, "protected reset starts nothing");
    bus_read(3'd3, r); chk(r, 8'h22, 9, "protected reset keeps sibling");

    // R11 status upper bits stay zero while busy
    bus_write(3'd0, 8'h02, 1'b0);
    bus_read(3'd1, s); chk(s, 8'h01, 11, "status upper bits zero");
    wait_idle(n);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule